// File: doc/BRIEF.md
# Multi-channel prescaled PWM controller

This block is a bank of independent pulse-width modulators behind a small register bus. Each channel owns one 32-bit control word. The word holds an enable flag, an 8-bit duty value and a 13-bit prescale value. The prescale value divides the module clock into ticks, with each tick lasting the prescale value plus one clock cycles. A PWM period is always a frame of 256 ticks. The output stays high for the first duty-value ticks of the frame and low for the rest.

Software configures a channel by writing its control word. Channel n sits at byte address n*16. A channel is stopped by clearing its enable bit with a read-modify-write, which leaves duty and prescale intact, or by writing zero, which also clears them. While a channel is running, a change of duty or prescale is held back until the current frame ends. This keeps every frame whole and free of glitches.

Top module: `pwm_bank`

## Requirements
- R1: The control word layout is: bit 31 enables the channel, bits 23:16 hold the duty value, and bits 12:0 hold the prescale value. Channel n is addressed at byte address n*16, with address bits 3:0 equal to zero.
- R2: A read request presents the full 32-bit word last written to the addressed channel on the read data port one clock cycle after the request. Reset clears every word to zero.
- R3: A read of an address that selects no channel returns zero. This covers a nonzero offset within the 16-byte stride and a channel index of NUM_CH or above. A write to such an address changes no channel word and no output.
- R4: A disabled channel drives its output low. After a write that clears the enable bit, the output is low from the second clock edge after the write.
- R5: One tick lasts prescale+1 clock cycles, and one frame lasts 256 ticks.
- R6: Within a frame, the output is high during ticks 0 to duty-1 and low during the remaining ticks. A duty of 0 gives a constant low output, and a duty of 255 gives an output that is low only during the last tick.
- R7: After a write that sets the enable bit of a stopped channel, tick 0 of the first frame starts at the second clock edge after the write, so the frame starts from a fresh state.
- R8: A duty or prescale value written while a channel runs takes effect at the start of the next frame. The current frame completes with the old values.
- R9: Writing zero stops a channel and clears its fields. Clearing only the enable bit keeps the duty and prescale fields, and setting the enable bit again restarts the channel at tick 0.
- R10: Each channel's output depends only on its own control word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 selects a write, 0 selects a read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pwm_o | output | NUM_CH | Registered PWM outputs, one bit per channel |

## Verification
A write lands in the control word at the first clock edge. A channel reacts at the second edge, so the bench counts tick 0 from the first sample taken after that second edge. Sample k of a run is expected high when floor(k/(prescale+1)) mod 256 is below the duty in force. The bench samples every cycle of whole frames on falling edges, which checks frame length and pattern together. Read data is due one edge after the request and is taken at the next falling edge. A mid-frame update is checked to stay invisible until sample 256*(prescale+1), with the new prescale in force from that point.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned EN_BIT    = 31;
  localparam int unsigned DUTY_LSB  = 16;
  localparam int unsigned SCALE_LSB = 0;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned STRIDE_LG = 4
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          bus_sel,
  input  logic                                          bus_wr,
  input  logic [ADDR_W-1:0]                             bus_addr,
  input  logic [pwm_bank_pkg::WORD_W-1:0]               bus_wdata,
  output logic [pwm_bank_pkg::WORD_W-1:0]               bus_rdata,
  output logic [NUM_CH-1:0][pwm_bank_pkg::WORD_W-1:0]   ctrl
);
  localparam int unsigned IDX_W = ADDR_W - STRIDE_LG;

  logic [IDX_W-1:0]       idx;
  logic                   aligned;
  logic [NUM_CH-1:0]      hit;
  logic [pwm_bank_pkg::WORD_W-1:0] rd_mux;

  assign idx     = bus_addr[ADDR_W-1:STRIDE_LG];
  assign aligned = (bus_addr[STRIDE_LG-1:0] == '0);

  // One-hot channel match; out-of-range indices match nothing.
  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      hit[c] = aligned && (idx == IDX_W'(c));
      if (hit[c]) rd_mux = ctrl[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      bus_rdata <= '0;
    end else if (bus_sel) begin
      if (bus_wr) begin
        for (int c = 0; c < NUM_CH; c++)
          if (hit[c]) ctrl[c] <= bus_wdata;
      end else begin
        bus_rdata <= rd_mux;
      end
    end
  end
endmodule

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int unsigned SCALE_W = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic [SCALE_W-1:0] limit,
  output logic               tick
);
  logic [SCALE_W-1:0] cnt;

  assign tick = !clr && (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr || tick) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int unsigned DUTY_W  = 8,
  parameter int unsigned SCALE_W = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [DUTY_W-1:0]  duty,
  input  logic [SCALE_W-1:0] scale,
  output logic               pwm_o
);
  logic               run;
  logic [DUTY_W-1:0]  act_duty;
  logic [SCALE_W-1:0] act_scale;
  logic [DUTY_W-1:0]  tick_cnt;
  logic               tick;
  logic               last;
  logic [DUTY_W:0]    next_pos;

  pwm_tick_gen #(.SCALE_W(SCALE_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (!run || !en),
    .limit(act_scale),
    .tick (tick)
  );

  assign last     = tick && (tick_cnt == '1);
  assign next_pos = {1'b0, tick_cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      run       <= 1'b0;
      act_duty  <= '0;
      act_scale <= '0;
      tick_cnt  <= '0;
      pwm_o     <= 1'b0;
    end else if (!run || last) begin
      // Frame start: take the configuration in force for the whole frame.
      run       <= 1'b1;
      act_duty  <= duty;
      act_scale <= scale;
      tick_cnt  <= '0;
      pwm_o     <= (duty != '0);
    end else if (tick) begin
      tick_cnt  <= tick_cnt + 1'b1;
      pwm_o     <= (next_pos < {1'b0, act_duty});
    end
  end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned STRIDE_LG = 4,
  parameter int unsigned DUTY_W    = 8,
  parameter int unsigned SCALE_W   = 13
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            bus_sel,
  input  logic                            bus_wr,
  input  logic [ADDR_W-1:0]               bus_addr,
  input  logic [pwm_bank_pkg::WORD_W-1:0] bus_wdata,
  output logic [pwm_bank_pkg::WORD_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0]               pwm_o
);
  import pwm_bank_pkg::*;

  logic [NUM_CH-1:0][WORD_W-1:0] ctrl;
  logic [NUM_CH-1:0]             chan_en;
  logic [NUM_CH-1:0]             unused_rsvd;

  pwm_regs #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .STRIDE_LG(STRIDE_LG)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .ctrl     (ctrl)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign chan_en[g]     = ctrl[g][EN_BIT];
    assign unused_rsvd[g] = ^{ctrl[g][EN_BIT-1:DUTY_LSB+DUTY_W],
                              ctrl[g][DUTY_LSB-1:SCALE_LSB+SCALE_W]};

    pwm_chan #(.DUTY_W(DUTY_W), .SCALE_W(SCALE_W)) u_chan (
      .clk  (clk),
      .rst  (rst),
      .en   (chan_en[g]),
      .duty (ctrl[g][DUTY_LSB +: DUTY_W]),
      .scale(ctrl[g][SCALE_LSB +: SCALE_W]),
      .pwm_o(pwm_o[g])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned STRIDE_LG = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [NUM_CH-1:0] pwm_o,
  input logic [NUM_CH-1:0] en_q
);
  logic mapped;
  assign mapped = (bus_addr[STRIDE_LG-1:0] == '0) &&
                  ((bus_addr >> STRIDE_LG) < ADDR_W'(NUM_CH));

  // R3: unmapped reads return zero
  p_unmapped_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && !mapped) |=> (bus_rdata == '0));

  // R2: a write followed by a read of the same address returns the data
  p_readback_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && mapped) ##1
    (bus_sel && !bus_wr && bus_addr == $past(bus_addr))
    |=> (bus_rdata == $past(bus_wdata, 2)));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    // R4: a disabled channel is low on the following cycle
    p_disabled_low_r4: assert property (@(posedge clk) disable iff (rst)
      !en_q[g] |=> !pwm_o[g]);
    // R7: output can only be high if the channel was enabled before
    p_high_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
      pwm_o[g] |-> $past(en_q[g]));
  end
endmodule

bind pwm_bank pwm_bank_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .STRIDE_LG(STRIDE_LG)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pwm_o    (pwm_o),
  .en_q     (chan_en)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NUM_CH-1:0] pwm_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_bank u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_o(pwm_o)
  );

  function automatic logic [31:0] word(bit en, int duty, int scale);
    return {en, 7'd0, 8'(duty), 3'd0, 13'(scale)};
  endfunction

  function automatic bit exp_bit(int k, int duty, int scale);
    return ((k / (scale + 1)) % 256) < duty;
  endfunction

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // Enable one channel, check every cycle of one frame, then stop it.
  task automatic run_frame(int ch, int duty, int scale, string req);
    logic [NUM_CH-1:0] e;
    bus_write(8'(ch * 16), word(1'b1, duty, scale));
    for (int k = 0; k < 256 * (scale + 1); k++) begin
      @(negedge clk);
      e = '0;
      e[ch] = exp_bit(k, duty, scale);
      check32(req, 32'(pwm_o), 32'(e));
    end
    bus_write(8'(ch * 16), 32'd0);
    @(negedge clk);
    check32("R4 stopped after frame", 32'(pwm_o), 32'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks, fails);
      $finish;
    end
  endtask

  initial begin
    logic [31:0] rd;
    logic [NUM_CH-1:0] e;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Reset state (R2, R4)
    check32("R4 reset outputs low", 32'(pwm_o), 32'd0);
    for (int c = 0; c < NUM_CH; c++) begin
      bus_read(8'(c * 16), rd);
      check32("R2 reset word zero", rd, 32'd0);
    end

    // R1/R2: layout readback including full prescale range
    bus_write(8'h20, word(1'b0, 8'hFF, 13'h1FFF));
    bus_read(8'h20, rd);
    check32("R1 field layout readback", rd, 32'h00FF1FFF);
    bus_write(8'h30, 32'hDEADBEEF & 32'h7FFFFFFF);
    bus_read(8'h30, rd);
    check32("R2 full word readback", rd, 32'h5EADBEEF);
    bus_write(8'h20, 32'd0);
    bus_write(8'h30, 32'd0);

    // R5/R6/R7 sweeps across channels, duties and prescales
    run_frame(0, 0,   0, "R6 duty zero");
    run_frame(0, 1,   0, "R6 duty one");
    run_frame(0, 128, 0, "R6 half duty");
    run_frame(0, 255, 0, "R6 duty 255");
    run_frame(1, 3,   1, "R5 prescale 1");
    run_frame(1, 254, 1, "R5 prescale 1 high duty");
    run_frame(2, 100, 2, "R5 prescale 2");
    run_frame(3, 37,  4, "R7 prescale 4 start");

    // R8: update mid-frame, effective at next frame
    bus_write(8'h00, word(1'b1, 200, 0));
    for (int k = 0; k < 256 + 512; k++) begin
      @(negedge clk);
      if (k < 256) e = {3'b000, exp_bit(k, 200, 0)};
      else         e = {3'b000, exp_bit(k - 256, 10, 1)};
      check32("R8 deferred update", 32'(pwm_o), 32'(e));
      if (k == 50) begin
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h00;
        bus_wdata = word(1'b1, 10, 1);
      end else if (k == 51) begin
        bus_sel = 1'b0; bus_wr = 1'b0;
      end
    end

    // R9: read-modify-write of the enable bit
    bus_read(8'h00, rd);
    check32("R9 running word", rd, 32'h800A0001);
    bus_write(8'h00, rd & 32'h7FFFFFFF);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check32("R4 low after enable cleared", 32'(pwm_o), 32'd0);
    end
    bus_read(8'h00, rd);
    check32("R9 fields kept", rd, 32'h000A0001);
    bus_write(8'h00, rd | 32'h80000000);
    for (int k = 0; k < 512; k++) begin
      @(negedge clk);
      check32("R9 restart at tick 0", 32'(pwm_o),
              32'(exp_bit(k, 10, 1)));
    end
    bus_write(8'h00, 32'd0);
    bus_read(8'h00, rd);
    check32("R9 zero write clears", rd, 32'd0);
    @(negedge clk);
    check32("R9 zero write stops", 32'(pwm_o), 32'd0);

    // R3: unmapped addresses
    bus_write(8'h00, word(1'b0, 8'h55, 3));
    bus_write(8'h04, 32'hFFFFFFFF);
    bus_write(8'h40, 32'hFFFFFFFF);
    bus_write(8'hF0, 32'hFFFFFFFF);
    bus_read(8'h04, rd);
    check32("R3 offset read zero", rd, 32'd0);
    bus_read(8'h40, rd);
    check32("R3 index read zero", rd, 32'd0);
    bus_read(8'hF0, rd);
    check32("R3 top index read zero", rd, 32'd0);
    bus_read(8'h00, rd);
    check32("R3 ch0 untouched", rd, 32'h00550003);
    for (int c = 1; c < NUM_CH; c++) begin
      bus_read(8'(c * 16), rd);
      check32("R3 other channel untouched", rd, 32'd0);
    end
    check32("R3 outputs untouched", 32'(pwm_o), 32'd0);
    bus_write(8'h00, 32'd0);

    // R10: two channels running at once
    bus_write(8'h20, word(1'b1, 128, 0));
    bus_write(8'h10, word(1'b1, 64, 0));
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      e = '0;
      e[1] = exp_bit(k, 64, 0);
      e[2] = exp_bit(k + 2, 128, 0);
      check32("R10 independent channels", 32'(pwm_o), 32'(e));
    end

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule